// File: doc/BRIEF.md
# Edge-Timestamp Pulse Width Capture

This block measures the duration of pulses on a single input line. A free-running timestamp counter is copied into one of four capture registers each time the input shows the edge selected for the current capture slot. Each slot has its own polarity, so slot 1 can catch the leading edge and slot 2 the trailing edge of the same pulse. If the counter is set to restart when slot 1 fires, capture register 2 holds the pulse width in clock cycles, and software needs no subtraction.

Capture is one-shot. A programmable stop slot ends the sequence, and later edges are ignored until software writes the re-arm strobe. Capture events and counter wrap raise sticky flags. A global flag, which drives the interrupt pin, sets whenever a flag whose enable bit is 1 sets. Software clears flags by writing ones to a clear register. Access is through a simple word-wide register port with byte strobes.

Top module: `edge_pulse_capture`

## Requirements
- R1: After reset, the control, enable and flag registers and all capture registers read 0 and `irq` is 0. The sequencer starts stopped, so edges cause no capture and set no flag until a re-arm write.
- R2: The timestamp counts once per cycle while control 2 bit 4 (word 0x28, bit 20) is 1. While that bit is 0 the count holds.
- R3: Control 1 sets the edge for each slot: bit 0 for slot 1, bit 2 for slot 2, bit 4 for slot 3 and bit 6 for slot 4. A value of 0 means rising and 1 means falling. The input passes through a two-flop synchronizer before edge detection.
- R4: When control 1 bit 1 is 1, a slot-1 capture restarts the counter, which reads 1 in the next cycle. Capture register 2 then equals the pulse length in cycles. When the bit is 0, capture 2 minus capture 1 (modulo 2^TS_W) equals the pulse length.
- R5: When control 1 bit 8 is 0, the capture registers keep their values. Events still advance the sequence and still set their flags.
- R6: The slot index advances 1, 2, 3, 4. When the slot equal to control 2 bits 2:1 plus one has been captured, edges are ignored until control 2 bit 3 is written as 1. That write returns the sequence to slot 1. Bit 3 always reads 0.
- R7: In the flag register (word 0x2C, bits 21:16), bits 1 to 4 are slots 1 to 4 and bit 5 is counter wrap. Writing a 1 to a bit of the clear register (0x30, bits 5:0) clears the matching flag. Writing a 0 has no effect.
- R8: Flag bit 0 sets when a flag bit sets whose enable bit is 1 in the enable register (0x2C, bits 5:1). `irq` equals flag bit 0. Flag bit 0 is cleared by writing 1 to clear bit 0.
- R9: While `dbg_halt` is 1, the counter holds unless control 1 bit 15 is 1.
- R10: A wrap of the counter from all ones to 0 sets flag bit 5.
- R11: A slot-1 capture that also restarts the counter stores the value from before the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| byte_en | input | 4 | Byte lanes of a write |
| rdata | output | 32 | Read data for `addr`, combinational |
| sig_in | input | 1 | Signal being measured, asynchronous |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 1 | Interrupt, equal to flag bit 0 |

Register words: 0x08, 0x0C, 0x10 and 0x14 are capture registers 1 to 4. Word 0x28 holds control 1 in bits 15:0 and control 2 in bits 31:16. Word 0x2C holds the enable register in bits 15:0 and the flag register in bits 31:16. Word 0x30 is the clear register.

## Verification
The clocked checks assume that software changes neither the interrupt enable register nor the edge polarities in the same cycle as a capture. They also assume that a re-arm write never coincides with a qualifying edge. The bench keeps within these assumptions by changing configuration only while the input is idle and the sequencer is stopped, and by starting every pulse after the re-arm write has completed. Pulse widths are swept over both polarities, and every expected capture value is derived from the cycle numbers at which the bench drove the edges.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    localparam int N_EVT = 4;
    localparam int EVT_W = $clog2(N_EVT);

    // word indices (byte address >> 2)
    localparam logic [3:0] W_CAP1 = 4'd2;
    localparam logic [3:0] W_CAP2 = 4'd3;
    localparam logic [3:0] W_CAP3 = 4'd4;
    localparam logic [3:0] W_CAP4 = 4'd5;
    localparam logic [3:0] W_CTRL = 4'd10;
    localparam logic [3:0] W_INT  = 4'd11;
    localparam logic [3:0] W_CLR  = 4'd12;

    localparam logic [15:0] CTRL1_MASK = 16'h8157;
    localparam logic [15:0] CTRL2_MASK = 16'h0096;
    localparam logic [5:0]  IEN_MASK   = 6'h3E;

    localparam int C1_RST   = 1;
    localparam int C1_LDEN  = 8;
    localparam int C1_HFREE = 15;
    localparam int C2_REARM = 3;
    localparam int C2_RUN   = 4;

    typedef struct packed {
        logic [15:0] ctrl1;
        logic [15:0] ctrl2;
        logic [5:0]  ien;
        logic [5:0]  flag;
    } regs_t;
endpackage

// File: rtl/pcap_edge.sv
module pcap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], din};
        s_d.prev = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.sync[STAGES-1] & ~s_q.prev;
    assign fall = ~s_q.sync[STAGES-1] & s_q.prev;
endmodule

// File: rtl/pcap_timebase.sv
module pcap_timebase #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            dbg_halt,
    input  logic            halt_free,
    input  logic            restart,
    output logic [TS_W-1:0] cnt,
    output logic            ovf
);
    logic [TS_W-1:0] cnt_d, cnt_q;
    logic            en;

    always_comb begin
        en    = run && !(dbg_halt && !halt_free);
        cnt_d = cnt_q;
        if (restart)  cnt_d = TS_W'(1);
        else if (en)  cnt_d = cnt_q + 1'b1;
        ovf = en && !restart && (&cnt_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R2, R9: frozen counter holds its value
    a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !restart) |=> $stable(cnt_q));
    // R10: wrap indication is followed by a zero count
    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == '0));
    // R4: restart leaves the count at one
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == TS_W'(1)));
endmodule

// File: rtl/pcap_seq.sv
module pcap_seq
    import pcap_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rise,
    input  logic                       fall,
    input  logic [N_EVT-1:0]           pol,
    input  logic [EVT_W-1:0]           stop_sel,
    input  logic                       rearm,
    input  logic                       load_en,
    input  logic [TS_W-1:0]            cnt,
    output logic [N_EVT-1:0]           hit,
    output logic [N_EVT-1:0][TS_W-1:0] cap
);
    typedef struct packed {
        logic [N_EVT-1:0][TS_W-1:0] cap;
        logic [EVT_W-1:0]           idx;
        logic                       stopped;
    } st_t;

    st_t  s_d, s_q;
    logic edge_ok;

    always_comb begin
        s_d     = s_q;
        hit     = '0;
        edge_ok = pol[s_q.idx] ? fall : rise;
        if (rearm) begin
            s_d.idx     = '0;
            s_d.stopped = 1'b0;
        end else if (edge_ok && !s_q.stopped) begin
            hit[s_q.idx] = 1'b1;
            if (load_en) s_d.cap[s_q.idx] = cnt;
            if (s_q.idx == stop_sel) s_d.stopped = 1'b1;
            else                     s_d.idx     = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.stopped <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cap = s_q.cap;

    // R6: once stopped, nothing is captured until re-armed
    a_r6_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stopped && !rearm) |=> (s_q.stopped && $stable(s_q.cap)));
    // R5: with loading off, capture registers never change
    a_r5_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(s_q.cap));
endmodule

// File: rtl/edge_pulse_capture.sv
module edge_pulse_capture
    import pcap_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int TS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_en,
    input  logic [3:0]        byte_en,
    output logic [31:0]       rdata,
    input  logic              sig_in,
    input  logic              dbg_halt,
    output logic              irq
);
    localparam int WORD_W = ADDR_W - 2;

    regs_t                      r_d, r_q;
    logic [WORD_W-1:0]          word;
    logic                       wr_ctrl, wr_ien, wr_clr, rearm, restart;
    logic                       rise, fall, ovf, gset;
    logic [N_EVT-1:0]           hit;
    logic [N_EVT-1:0][TS_W-1:0] cap;
    logic [TS_W-1:0]            cnt;
    logic [5:0]                 clr, set6;
    logic                       unused_addr;

    assign word        = addr[ADDR_W-1:2];
    assign unused_addr = ^addr[1:0];
    assign wr_ctrl     = wr_en && (word == WORD_W'(W_CTRL));
    assign wr_ien      = wr_en && (word == WORD_W'(W_INT));
    assign wr_clr      = wr_en && (word == WORD_W'(W_CLR));
    assign rearm       = wr_ctrl && byte_en[2] && wdata[16+C2_REARM];
    assign restart     = hit[0] && r_q.ctrl1[C1_RST];

    pcap_edge #(.STAGES(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(sig_in), .rise(rise), .fall(fall)
    );

    pcap_timebase #(.TS_W(TS_W)) u_tb (
        .clk(clk), .rst_n(rst_n),
        .run(r_q.ctrl2[C2_RUN]), .dbg_halt(dbg_halt),
        .halt_free(r_q.ctrl1[C1_HFREE]), .restart(restart),
        .cnt(cnt), .ovf(ovf)
    );

    pcap_seq #(.TS_W(TS_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .pol({r_q.ctrl1[6], r_q.ctrl1[4], r_q.ctrl1[2], r_q.ctrl1[0]}),
        .stop_sel(r_q.ctrl2[2:1]), .rearm(rearm),
        .load_en(r_q.ctrl1[C1_LDEN]), .cnt(cnt), .hit(hit), .cap(cap)
    );

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            if (byte_en[0]) r_d.ctrl1[7:0]  = wdata[7:0]   & CTRL1_MASK[7:0];
            if (byte_en[1]) r_d.ctrl1[15:8] = wdata[15:8]  & CTRL1_MASK[15:8];
            if (byte_en[2]) r_d.ctrl2[7:0]  = wdata[23:16] & CTRL2_MASK[7:0];
            if (byte_en[3]) r_d.ctrl2[15:8] = wdata[31:24] & CTRL2_MASK[15:8];
        end
        if (wr_ien && byte_en[0]) r_d.ien = wdata[5:0] & IEN_MASK;
        clr    = (wr_clr && byte_en[0]) ? wdata[5:0] : 6'h00;
        set6   = {ovf, hit, 1'b0};
        gset   = |(set6 & r_q.ien);
        r_d.flag = (r_q.flag & ~clr) | set6 | {5'b0, gset};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (word)
            WORD_W'(W_CAP1): rdata = 32'(cap[0]);
            WORD_W'(W_CAP2): rdata = 32'(cap[1]);
            WORD_W'(W_CAP3): rdata = 32'(cap[2]);
            WORD_W'(W_CAP4): rdata = 32'(cap[3]);
            WORD_W'(W_CTRL): rdata = {r_q.ctrl2, r_q.ctrl1};
            WORD_W'(W_INT):  rdata = {10'b0, r_q.flag, 10'b0, r_q.ien};
            default:         rdata = '0;
        endcase
    end

    assign irq = r_q.flag[0];

    // R8: the global flag only rises because an enabled source flag is set
    a_r8_global_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.flag[0]) |-> (|(r_q.flag[5:1] & r_q.ien[5:1])));
    // R7: a flag with no new event stays cleared after a write of one
    a_r7_clear_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[5] && !ovf) |=> !r_q.flag[5]);
endmodule

// File: tb/test_edge_pulse_capture.sv
`timescale 1ns/1ps
module test_edge_pulse_capture;
    localparam int TS_W = 10;
    localparam logic [31:0] MASK = (32'd1 << TS_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  byte_en = '0;
    logic [31:0] rdata;
    logic        sig = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    int tr1, tf1, tr2, tf2;
    logic [31:0] d, c1, c2;

    edge_pulse_capture #(.ADDR_W(6), .TS_W(TS_W)) i_edge_pulse_capture (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .byte_en(byte_en), .rdata(rdata), .sig_in(sig), .dbg_halt(dbg_halt),
        .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v, input logic [3:0] be);
        @(negedge clk);
        addr = a; wdata = v; byte_en = be; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic set_c1(input logic [15:0] v);
        wr(6'h28, {16'h0, v}, 4'b0011);
    endtask

    // re-arm with a stop slot; run bit selectable
    task automatic arm(input int stop, input bit run);
        wr(6'h28, {16'(((run ? 1 : 0) << 4) | 8 | (stop << 1)), 16'h0}, 4'b1100);
    endtask

    task automatic clr_flags();
        wr(6'h30, 32'h3F, 4'b0001);
    endtask

    task automatic pulse(input bit active, input int w, output int t_r, output int t_f);
        @(negedge clk);
        sig = active; t_r = cyc;
        repeat (w) @(negedge clk);
        sig = ~active; t_f = cyc;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(6'h28, d); chk("R1 ctrl", d, 0);
        rd(6'h2C, d); chk("R1 int", d, 0);
        rd(6'h08, d); chk("R1 cap1", d, 0);
        rd(6'h0C, d); chk("R1 cap2", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        // R1: no capture before re-arm
        wr(6'h28, {16'h0010, 16'h0106}, 4'b1111);
        pulse(1, 5, tr1, tf1); settle();
        rd(6'h2C, d); chk("R1 no flags unarmed", d, 0);
        rd(6'h0C, d); chk("R1 no cap unarmed", d, 0);

        wr(6'h2C, 32'h3E, 4'b0001);
        // R3/R4 high pulse sweep with restart
        for (int w = 1; w <= 24; w++) begin
            clr_flags(); arm(1, 1);
            pulse(1, w, tr1, tf1); settle();
            rd(6'h0C, d); chk("R4 high width", d, tf1 - tr1);
            rd(6'h2C, d); chk("R7 event flags", {29'b0, d[18:16]}, 7);
        end
        // R3 low pulse sweep: swapped polarities
        sig = 1'b1; settle();
        set_c1(16'h0103);
        for (int w = 1; w <= 24; w++) begin
            arm(1, 1);
            pulse(0, w, tr1, tf1); settle();
            rd(6'h0C, d); chk("R3 low width", d, tf1 - tr1);
        end
        sig = 1'b0; settle();
        // R4 without restart: difference
        set_c1(16'h0104);
        for (int w = 3; w <= 33; w += 10) begin
            arm(1, 1);
            pulse(1, w, tr1, tf1); settle();
            rd(6'h08, c1); rd(6'h0C, c2);
            chk("R4 diff", (c2 - c1) & MASK, w);
        end
        // R2 frozen counter
        arm(1, 0);
        pulse(1, 9, tr1, tf1); settle();
        rd(6'h08, c1); rd(6'h0C, c2);
        chk("R2 frozen", c2, c1);
        // R9 debug halt
        dbg_halt = 1'b1;
        arm(1, 1);
        pulse(1, 7, tr1, tf1); settle();
        rd(6'h08, c1); rd(6'h0C, c2);
        chk("R9 halted", c2, c1);
        set_c1(16'h8104);
        arm(1, 1);
        pulse(1, 7, tr1, tf1); settle();
        rd(6'h08, c1); rd(6'h0C, c2);
        chk("R9 free in halt", (c2 - c1) & MASK, 7);
        dbg_halt = 1'b0;
        // R5 load disabled
        set_c1(16'h0004);
        rd(6'h08, c1); rd(6'h0C, c2);
        clr_flags(); arm(1, 1);
        pulse(1, 11, tr1, tf1); settle();
        rd(6'h08, d); chk("R5 cap1 kept", d, c1);
        rd(6'h0C, d); chk("R5 cap2 kept", d, c2);
        rd(6'h2C, d); chk("R5 flags set", {30'b0, d[18:17]}, 3);
        // R6 one-shot, stop after slot 1
        set_c1(16'h0106);
        clr_flags(); arm(0, 1);
        rd(6'h28, d); chk("R6 rearm reads 0", {16'h0, d[31:16]}, 32'h10);
        pulse(1, 6, tr1, tf1); settle();
        rd(6'h2C, d); chk("R6 only slot1", {28'b0, d[20:17]}, 1);
        clr_flags();
        pulse(1, 6, tr1, tf1); settle();
        rd(6'h2C, d); chk("R6 ignored when stopped", {28'b0, d[20:17]}, 0);
        // R6/R3 four slots, slot 3 rising, slot 4 falling
        set_c1(16'h0146);
        clr_flags(); arm(3, 1);
        pulse(1, 5, tr1, tf1);
        repeat (4) @(negedge clk);
        pulse(1, 8, tr2, tf2); settle();
        rd(6'h0C, d); chk("R6 cap2", d, tf1 - tr1);
        rd(6'h10, d); chk("R6 cap3", d, tr2 - tr1);
        rd(6'h14, d); chk("R6 cap4", d, tf2 - tr1);
        rd(6'h2C, d); chk("R6 four flags", {28'b0, d[20:17]}, 15);
        // R11 slot-1 capture keeps pre-restart value
        arm(0, 1);
        pulse(1, 3, tr2, tf2); settle();
        rd(6'h08, d); chk("R11 old value", d, (tr2 - tr1) & MASK);
        // R7/R8 write-one-to-clear
        wr(6'h2C, 32'h1E, 4'b0001);
        clr_flags(); arm(1, 1);
        pulse(1, 4, tr1, tf1); settle();
        rd(6'h2C, d); chk("R8 global set", {27'b0, d[20:16]}, 7);
        wr(6'h30, 32'h00, 4'b0001);
        rd(6'h2C, d); chk("R7 zero no effect", {27'b0, d[20:16]}, 7);
        wr(6'h30, 32'h02, 4'b0001);
        rd(6'h2C, d); chk("R7 clear one", {27'b0, d[20:16]}, 5);
        chk("R8 irq held", {31'b0, irq}, 1);
        wr(6'h30, 32'h05, 4'b0001);
        rd(6'h2C, d); chk("R7 clear rest", {27'b0, d[20:16]}, 0);
        #1 chk("R8 irq low", {31'b0, irq}, 0);
        // R8 disabled sources do not set global
        wr(6'h2C, 32'h00, 4'b0001);
        clr_flags(); arm(1, 1);
        pulse(1, 4, tr1, tf1); settle();
        rd(6'h2C, d); chk("R8 no global", {27'b0, d[20:16]}, 6);
        chk("R8 irq off", {31'b0, irq}, 0);
        // R10 counter wrap
        wr(6'h2C, 32'h20, 4'b0001);
        clr_flags();
        repeat ((1 << TS_W) + 8) @(negedge clk);
        rd(6'h2C, d); chk("R10 wrap flag", {30'b0, d[21], d[16]}, 3);
        chk("R10 irq", {31'b0, irq}, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule